// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Burst Counter

This block is a single-port synchronous static memory whose command interface never needs an idle cycle when the bus changes direction. Address and control are captured on the rising clock edge. Write data follows its command by the same number of cycles as read data does, so a read, a write and another read can be issued on three consecutive edges. A static mode pin selects one of two timings. In the registered timing, read data comes out through an output register and write data is taken two edges after the command. In the flow-through timing, read data is driven straight from the array and write data is taken one edge after the command.

A 2-bit burst generator sits on the low address bits. A load cycle starts an access at a new address. Each continue cycle steps to the next word of an aligned group of four, in linear or interleaved order. Writes select 9-bit byte lanes through active-low lane enables. A clock-enable input freezes the whole block for an edge. Three chip selects gate new accesses, and an asynchronous output-enable pin masks the output drive. While a write still waits for its data, a read of the same word in registered timing returns the pending lanes merged with the array contents.

The data path is split: the block drives `rdata` together with a drive qualifier `rdata_oe`. An enclosing pad or bus model turns this pair into a tri-state pin.

Top module: `lwsram`

## Requirements
- R1: In registered timing (`flow_mode`=0), a read captured at enabled edge k drives `rdata_oe`=1 with the word after enabled edge k+1. After edge k itself the qualifier still reflects the previous slot.
- R2: In flow-through timing (`flow_mode`=1), a read captured at edge k drives the word with `rdata_oe`=1 right after edge k.
- R3: A write captured at enabled edge k takes `wdata` at enabled edge k+2 in registered timing and at enabled edge k+1 in flow-through timing.
- R4: `be_n[i]`=0 writes lane i, which is bits [9i+8:9i]. Lanes whose bit is 1 keep their contents. A write with `be_n`=4'b1111 changes nothing.
- R5: `adv`=1 continues the burst. Address bits [AW-1:2] are kept, and with `burst_ilv`=0 the low two bits are start+n mod 4. After four accesses the sequence returns to the start.
- R6: With `burst_ilv`=1, the low two bits of the n-th burst access are start XOR n.
- R7: A continue cycle reuses the type of the access that opened the burst and ignores `we_n` and the chip selects. A continue after a deselect, or straight after reset, performs no access.
- R8: A load cycle (`adv`=0) with `cs1_n`=1, `cs2`=0 or `cs3_n`=1 is a deselect: nothing is written and nothing is driven.
- R9: An edge with `clk_en_n`=1 changes no state. An active registered read keeps driving the same word, no write lands, and `wdata` on that edge is ignored.
- R10: `oe_n`=1 forces `rdata_oe` low without waiting for a clock edge. A read issued with `oe_n`=1 still performs its access.
- R11: The slot of a write command never drives `rdata_oe`, even with `oe_n` held low.
- R12: In registered timing, a read of the word addressed by the write issued one edge before it returns that write's enabled lanes, taken from `wdata`, merged with the array contents in the other lanes.
- R13: After reset, `rdata_oe` is 0, no write is pending and the burst state is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flow_mode | input | 1 | 0 = registered read with two-edge write lag, 1 = flow-through read with one-edge lag (static) |
| burst_ilv | input | 1 | 0 = linear burst order, 1 = interleaved (static) |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| adv | input | 1 | 0 = load a new access, 1 = continue the burst |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| we_n | input | 1 | 0 = write, 1 = read (load cycles only) |
| be_n | input | LANES | Active-low byte-lane write enables |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | AW | Word address |
| wdata | input | LANES*LANE_W | Late write data |
| rdata | output | LANES*LANE_W | Read data |
| rdata_oe | output | 1 | High when `rdata` is to be driven onto the bus |

## Verification
The embedded properties check on every cycle that a disabled edge leaves the registered output word and its valid flag untouched. They also check that a registered-timing write slot never drives the output, and that a continue cycle keeps both the access type and the upper address bits. The directed scenarios show the things that depend on data values and sequences: the latency of each timing, the lane merging, write aborts, the linear and interleaved orders including the wrap on the fifth access, and forwarding of a pending write into a read. They also show the asynchronous output mask, deselects, and a write stretched across a stalled edge.

// File: rtl/lwsram_pkg.sv
`timescale 1ns/1ps
package lwsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lwsram_burst.sv
`timescale 1ns/1ps
// Command capture and 2-bit burst address sequencing (first pipeline stage).
module lwsram_burst
  import lwsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          adv,
  input  logic          sel,
  input  logic          we_n,
  input  logic          ilv,
  input  logic [AW-1:0] addr,
  output op_e           op_q,
  output logic [AW-1:0] addr_q
);
  logic [1:0] base_lo;
  logic [1:0] cnt;
  logic [1:0] cnt_nx;
  logic [1:0] lo_nx;

  assign cnt_nx = cnt + 2'd1;
  assign lo_nx  = ilv ? (base_lo ^ cnt_nx) : (base_lo + cnt_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      base_lo <= '0;
      cnt     <= '0;
      addr_q  <= '0;
    end else if (en) begin
      if (!adv) begin
        op_q    <= sel ? (we_n ? OP_READ : OP_WRITE) : OP_IDLE;
        base_lo <= addr[1:0];
        cnt     <= '0;
        addr_q  <= addr;
      end else begin
        cnt    <= cnt_nx;
        addr_q <= {addr_q[AW-1:2], lo_nx};
      end
    end
  end

  // R5: a continue step stays inside its aligned group of four words
  a_r5_same_block: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv) |=> (addr_q[AW-1:2] == $past(addr_q[AW-1:2])));

  // R7: a continue step keeps the access type of the burst
  a_r7_keep_op: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv) |=> $stable(op_q));
endmodule

// File: rtl/lwsram_array.sv
`timescale 1ns/1ps
// Storage: one register array per byte lane, combinational read.
module lwsram_array #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES-1:0]        wbe_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && !wbe_n[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end
    assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/lwsram.sv
`timescale 1ns/1ps
module lwsram
  import lwsram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flow_mode,
  input  logic                    burst_ilv,
  input  logic                    clk_en_n,
  input  logic                    adv,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        be_n,
  input  logic                    oe_n,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int DW = LANES * LANE_W;

  logic             en;
  logic             sel;
  op_e              op1;
  logic [AW-1:0]    addr1;
  logic [LANES-1:0] be1;
  op_e              op2;
  logic [AW-1:0]    addr2;
  logic [LANES-1:0] be2;
  logic             commit_we;
  logic [AW-1:0]    commit_addr;
  logic [LANES-1:0] commit_be;
  logic [DW-1:0]    arr_rd;
  logic [DW-1:0]    merged;
  logic             fwd_hit;
  logic [DW-1:0]    out_q;
  logic             out_valid;
  logic             drive;

  assign en  = !clk_en_n;
  assign sel = !cs1_n && cs2 && !cs3_n;

  // Stage 1: command capture and burst addressing
  lwsram_burst #(.AW(AW)) i_burst (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .adv    (adv),
    .sel    (sel),
    .we_n   (we_n),
    .ilv    (burst_ilv),
    .addr   (addr),
    .op_q   (op1),
    .addr_q (addr1)
  );

  // Lane enables follow each access, including burst continues
  // Stage 2: second slot of the registered-timing write lag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      be1   <= '1;
      op2   <= OP_IDLE;
      addr2 <= '0;
      be2   <= '1;
    end else if (en) begin
      be1   <= be_n;
      op2   <= op1;
      addr2 <= addr1;
      be2   <= be1;
    end
  end

  // Write commit: one stage back in flow-through, two in registered timing
  always_comb begin
    if (flow_mode) begin
      commit_we   = en && (op1 == OP_WRITE);
      commit_addr = addr1;
      commit_be   = be1;
    end else begin
      commit_we   = en && (op2 == OP_WRITE);
      commit_addr = addr2;
      commit_be   = be2;
    end
  end

  lwsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_array (
    .clk   (clk),
    .we    (commit_we),
    .waddr (commit_addr),
    .wbe_n (commit_be),
    .wdata (wdata),
    .raddr (addr1),
    .rdata (arr_rd)
  );

  // Forwarding of the write whose data arrives on this edge
  assign fwd_hit = (op2 == OP_WRITE) && (addr2 == addr1);

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*LANE_W +: LANE_W] = (fwd_hit && !be2[l])
      ? wdata[l*LANE_W +: LANE_W] : arr_rd[l*LANE_W +: LANE_W];
  end

  // Registered-timing output stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q     <= '0;
      out_valid <= 1'b0;
    end else if (en) begin
      out_q     <= merged;
      out_valid <= (op1 == OP_READ);
    end
  end

  assign drive    = flow_mode ? (op1 == OP_READ) : out_valid;
  assign rdata    = flow_mode ? arr_rd : out_q;
  assign rdata_oe = drive && !oe_n;

  // R9: a disabled edge leaves the registered output untouched
  a_r9_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> ($stable(out_q) && $stable(out_valid)));

  // R11: the output slot of a registered write is never driven
  a_r11_quiet_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !flow_mode && op1 == OP_WRITE) |=> !rdata_oe);
endmodule

// File: tb/test_lwsram.sv
`timescale 1ns/1ps
module test_lwsram;
  localparam int AW = 6;
  localparam int LANES = 4;
  localparam int LANE_W = 9;
  localparam int DW = LANES * LANE_W;
  localparam logic [2:0] SEL = 3'b010;  // {cs1_n, cs2, cs3_n}
  localparam logic [2:0] DES = 3'b110;
  localparam logic [3:0] NONE = 4'hF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flow_mode = 1'b0, burst_ilv = 1'b0, clk_en_n = 1'b0, adv = 1'b0;
  logic cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [LANES-1:0] be_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lwsram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_lwsram (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .burst_ilv(burst_ilv),
    .clk_en_n(clk_en_n), .adv(adv), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .we_n(we_n), .be_n(be_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one slot, then wait to the following falling edge
  task automatic issue(input logic a, input logic [2:0] cs, input logic w,
                       input logic [3:0] b, input logic [AW-1:0] ad, input logic [DW-1:0] d);
    adv = a; {cs1_n, cs2, cs3_n} = cs; we_n = w; be_n = b; addr = ad; wdata = d;
    @(negedge clk);
  endtask

  task automatic nop(input logic [DW-1:0] d);
    issue(1'b0, DES, 1'b1, NONE, '0, d);
  endtask

  task automatic stall(input logic [DW-1:0] d);
    clk_en_n = 1'b1; wdata = d;
    @(negedge clk);
    clk_en_n = 1'b0;
  endtask

  // Read in flow-through timing and compare
  task automatic fread(input string req, input logic [AW-1:0] ad, input logic [DW-1:0] exp);
    issue(1'b0, SEL, 1'b1, NONE, ad, '0);
    check(req, {35'd0, rdata_oe}, 36'd1);
    check(req, rdata, exp);
  endtask

  function automatic logic [DW-1:0] lanes(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [3:0] b);
    logic [DW-1:0] r = old;
    for (int l = 0; l < LANES; l++)
      if (!b[l]) r[l*LANE_W +: LANE_W] = nw[l*LANE_W +: LANE_W];
    return r;
  endfunction

  localparam logic [DW-1:0] D1 = 36'h1_2345_6789;
  localparam logic [DW-1:0] D2 = 36'hA_BCDE_F012;
  localparam logic [DW-1:0] D3 = 36'h5_5555_5555;
  localparam logic [DW-1:0] D4 = 36'hA_AAAA_AAAA;
  localparam logic [DW-1:0] D6 = 36'h3_C3C3_C3C3;
  localparam logic [DW-1:0] GB = 36'hF_FFFF_FFFF;

  task automatic t_reset();
    check("R13 reset drive", {35'd0, rdata_oe}, 36'd0);
    issue(1'b1, SEL, 1'b1, NONE, '0, '0);  // continue straight after reset
    nop('0);
    check("R13/R7 continue after reset", {35'd0, rdata_oe}, 36'd0);
  endtask

  task automatic t_pipe_rw();
    issue(1'b0, SEL, 1'b0, 4'h0, 6'd5, GB);
    nop(GB);
    nop(D1);                                   // R3: data two edges late
    issue(1'b0, SEL, 1'b1, NONE, 6'd5, '0);
    check("R1 not yet driven", {35'd0, rdata_oe}, 36'd0);
    nop('0);
    check("R1 registered drive", {35'd0, rdata_oe}, 36'd1);
    check("R1/R3 registered data", rdata, D1);
    nop('0);
    check("R1 release", {35'd0, rdata_oe}, 36'd0);
  endtask

  task automatic t_flow_rw();
    issue(1'b0, SEL, 1'b0, 4'h0, 6'd7, GB);
    nop(D2);                                   // R3: data one edge late
    fread("R2/R3 flow read", 6'd7, D2);
    nop('0);
  endtask

  task automatic t_bytes();
    logic [DW-1:0] exp;
    issue(1'b0, SEL, 1'b0, 4'h0, 6'd20, GB);
    nop(D3);
    issue(1'b0, SEL, 1'b0, 4'b1101, 6'd20, GB);
    nop(D4);
    exp = lanes(D3, D4, 4'b1101);
    fread("R4 lane 1 merge", 6'd20, exp);
    issue(1'b0, SEL, 1'b0, 4'hF, 6'd20, GB);  // abort
    nop(D6);
    fread("R4 abort unchanged", 6'd20, exp);
  endtask

  task automatic t_burst();
    logic [DW-1:0] d [4];
    for (int i = 0; i < 4; i++) d[i] = 36'h0_1000_0000 + 36'(i * 7 + 3);
    issue(1'b0, SEL, 1'b0, 4'h0, 6'd9, GB);
    issue(1'b1, SEL, 1'b0, 4'h0, '0, d[0]);
    issue(1'b1, SEL, 1'b0, 4'h0, '0, d[1]);
    issue(1'b1, SEL, 1'b0, 4'h0, '0, d[2]);
    nop(d[3]);
    fread("R5 linear write 9", 6'd9, d[0]);
    fread("R5 linear write 10", 6'd10, d[1]);
    fread("R5 linear write 11", 6'd11, d[2]);
    fread("R5 linear write 8", 6'd8, d[3]);
    fread("R5 burst start 10", 6'd10, d[1]);
    issue(1'b1, SEL, 1'b1, NONE, '0, '0); check("R5 linear step 11", rdata, d[2]);
    issue(1'b1, SEL, 1'b1, NONE, '0, '0); check("R5 linear step 8", rdata, d[3]);
    issue(1'b1, SEL, 1'b1, NONE, '0, '0); check("R5 linear step 9", rdata, d[0]);
    issue(1'b1, SEL, 1'b1, NONE, '0, '0); check("R5 wrap to 10", rdata, d[1]);
    nop('0);
    burst_ilv = 1'b1;
    fread("R6 ilv start 9", 6'd9, d[0]);
    issue(1'b1, SEL, 1'b1, NONE, '0, '0); check("R6 ilv step 8", rdata, d[3]);
    issue(1'b1, SEL, 1'b1, NONE, '0, '0); check("R6 ilv step 11", rdata, d[2]);
    issue(1'b1, SEL, 1'b1, NONE, '0, '0); check("R6 ilv step 10", rdata, d[1]);
    nop('0);
    burst_ilv = 1'b0;
  endtask

  task automatic t_continue();
    issue(1'b0, SEL, 1'b0, 4'h0, 6'd16, GB);
    issue(1'b1, DES, 1'b1, 4'h0, '0, D3);      // selects and we_n ignored
    nop(D4);
    fread("R7 continue write 16", 6'd16, D3);
    fread("R7 continue write 17", 6'd17, D4);
    nop('0);
    issue(1'b1, SEL, 1'b1, NONE, 6'd16, '0);
    check("R7 deselect continue idle", {35'd0, rdata_oe}, 36'd0);
  endtask

  task automatic t_deselect();
    issue(1'b0, 3'b000, 1'b0, 4'h0, 6'd7, GB);  // cs2 low
    check("R8 no drive", {35'd0, rdata_oe}, 36'd0);
    nop(D6);
    issue(1'b0, 3'b011, 1'b0, 4'h0, 6'd7, GB);  // cs3_n high
    nop(D6);
    fread("R8 no write", 6'd7, D2);
    nop('0);
  endtask

  task automatic t_oe();
    oe_n = 1'b1;
    issue(1'b0, SEL, 1'b1, NONE, 6'd7, '0);
    check("R10 dummy read masked", {35'd0, rdata_oe}, 36'd0);
    #1 oe_n = 1'b0;
    #1 check("R10 async unmask", {35'd0, rdata_oe}, 36'd1);
    check("R10 dummy read data", rdata, D2);
    nop('0);
  endtask

  task automatic t_stall();
    issue(1'b0, SEL, 1'b1, NONE, 6'd5, '0);
    nop('0);
    check("R9 pre-stall drive", {35'd0, rdata_oe}, 36'd1);
    stall('0);
    check("R9 stalled read drives", {35'd0, rdata_oe}, 36'd1);
    check("R9 stalled read data", rdata, D1);
    issue(1'b0, SEL, 1'b0, 4'h0, 6'd6, GB);
    stall(GB);
    check("R9 stalled write quiet", {35'd0, rdata_oe}, 36'd0);
    nop(GB);
    nop(D6);
    issue(1'b0, SEL, 1'b1, NONE, 6'd6, '0);
    nop('0);
    check("R9 write across stall", rdata, D6);
  endtask

  task automatic t_forward();
    logic [DW-1:0] m;
    logic [DW-1:0] v;
    issue(1'b0, SEL, 1'b0, 4'h0, 6'd12, GB);
    nop(GB);
    nop(D3);
    issue(1'b0, SEL, 1'b0, 4'b1110, 6'd12, GB);
    issue(1'b0, SEL, 1'b1, NONE, 6'd12, '0);
    check("R11 write slot quiet", {35'd0, rdata_oe}, 36'd0);
    nop(D4);
    m = lanes(D3, D4, 4'b1110);
    check("R12 forward drive", {35'd0, rdata_oe}, 36'd1);
    check("R12 forwarded merge", rdata, m);
    issue(1'b0, SEL, 1'b1, NONE, 6'd5, '0);
    issue(1'b0, SEL, 1'b0, 4'h0, 6'd13, GB);
    check("R1 back-to-back read", rdata, D1);
    issue(1'b0, SEL, 1'b1, NONE, 6'd12, '0);
    check("R11 turnaround quiet", {35'd0, rdata_oe}, 36'd0);
    v = 36'h0_F0F0_F0F0;
    nop(v);
    check("R12 array holds merge", rdata, m);
    issue(1'b0, SEL, 1'b1, NONE, 6'd13, '0);
    nop('0);
    check("R3 no-gap write landed", rdata, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pipe_rw();
    flow_mode = 1'b1; nop('0);
    t_flow_rw();
    t_bytes();
    t_burst();
    t_continue();
    t_deselect();
    t_oe();
    flow_mode = 1'b0; nop('0); nop('0);
    t_stall();
    nop('0); nop('0);
    t_forward();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule